// File: doc/BRIEF.md
# Register-Operand Execute Unit

This combinational unit carries out the single-register instruction group of a small 8-bit controller whose instruction words are 13 bits wide. It takes an instruction word, the register operand already fetched from the register file, the accumulator and the carry flag. It returns an 8-bit result, a destination strobe (accumulator or register), write enables and values for the zero and carry flags, and a request to skip the next instruction.

The group covers move, complement, increment, decrement-and-skip, increment-and-skip, rotate through carry, nibble swap, and bit clear, set and test. Most operations come in two forms: one writes the accumulator, the other writes the register back. Register addressing, banking, the program counter and fetch timing belong to the surrounding core. A skip request costs the core one extra instruction cycle, which is two main clocks.

Top module: `reg_op_unit`

## Requirements
- R1: For single-register operations (instr[12:6] from 7'h12 to 7'h1F), an even opcode value asserts `wr_acc` and an odd one asserts `wr_reg`. Opcode 7'h11 (move register to itself) asserts `wr_reg`. The two strobes are never high together.
- R2: Opcode 7'h11 gives `result` = register operand and writes Z.
- R3: Opcodes 7'h12 and 7'h13 give the bitwise inverse of the operand and write Z.
- R4: Opcodes 7'h14 and 7'h15 give operand+1 modulo 256 and write Z. They do not touch C.
- R5: Opcodes 7'h16 and 7'h17 give operand-1 modulo 256. They raise `skip` exactly when that value is zero and write no flag.
- R6: Opcodes 7'h1E and 7'h1F give operand+1 modulo 256. They raise `skip` exactly when that value is zero and write no flag.
- R7: Opcodes 7'h18 and 7'h19 rotate right through carry: `result` = {c_in, operand[7:1]} and `c_out` = operand[0]. Only C is written.
- R8: Opcodes 7'h1A and 7'h1B rotate left through carry: `result` = {operand[6:0], c_in} and `c_out` = operand[7]. Only C is written.
- R9: Opcodes 7'h1C and 7'h1D exchange the two nibbles of the operand and write no flag.
- R10: Bit words have instr[12:11]=01, function field f=instr[10:9] and bit index b=instr[8:6]. f=00 writes the register with bit b cleared, and f=01 writes it with bit b set. All other bits are kept and no flag is written.
- R11: For bit words, f=10 raises `skip` when bit b is 0 and f=11 raises it when bit b is 1. Neither writes a destination or a flag.
- R12: Every other word (instr[12]=1, or instr[12:6] below 7'h11) writes no destination, no flag and no skip.
- R13: Whenever `z_we` is high, `z_out` is 1 exactly when `result` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 13 | Instruction word |
| reg_in | input | 8 | Register operand |
| acc_in | input | 8 | Accumulator value |
| c_in | input | 1 | Current carry flag |
| result | output | 8 | Computed value |
| wr_acc | output | 1 | Write result to accumulator |
| wr_reg | output | 1 | Write result to register |
| z_we | output | 1 | Update zero flag |
| z_out | output | 1 | New zero flag |
| c_we | output | 1 | Update carry flag |
| c_out | output | 1 | New carry flag |
| skip | output | 1 | Skip next instruction |

## Verification
The assertions assume settled, fully known inputs. They are evaluated only after every input has been driven to 0 or 1. The bench applies each input combination, waits a fixed delay so the combinational outputs can settle, and then samples. The sweep covers every 7-bit opcode value with every register value and both carry values. Because of this, every bit index, every wrap of the increment and decrement, and every rotate edge bit are reached.

// File: rtl/reg_op_unit.sv
module reg_op_unit #(
  parameter int DW = 8,
  parameter int IW = 13,
  parameter int AW = 6
) (
  input  logic [IW-1:0] instr,
  input  logic [DW-1:0] reg_in,
  input  logic [DW-1:0] acc_in,
  input  logic          c_in,
  output logic [DW-1:0] result,
  output logic          wr_acc,
  output logic          wr_reg,
  output logic          z_we,
  output logic          z_out,
  output logic          c_we,
  output logic          c_out,
  output logic          skip
);
  localparam int OPW = IW - AW;
  localparam int BIW = $clog2(DW);
  localparam int NIB = DW / 2;

  logic [OPW-1:0] op;
  logic [BIW-1:0] bsel;
  logic [DW-1:0]  bmask;
  logic [DW-1:0]  inc_v, dec_v;
  logic           is_bit;
  logic           to_acc;
  logic           acc_unused;

  assign op         = instr[IW-1:AW];
  assign bsel       = instr[AW +: BIW];
  assign bmask      = DW'(1) << bsel;
  assign inc_v      = reg_in + DW'(1);
  assign dec_v      = reg_in - DW'(1);
  assign is_bit     = op[OPW-1 -: 2] == 2'b01;
  assign to_acc     = ~op[0];
  assign acc_unused = ^acc_in;
  assign z_out      = result == '0;

  always_comb begin
    result = reg_in;
    wr_acc = 1'b0;
    wr_reg = 1'b0;
    z_we   = 1'b0;
    c_we   = 1'b0;
    c_out  = c_in;
    skip   = 1'b0;
    if (is_bit) begin
      case (op[4:3])
        2'b00: begin result = reg_in & ~bmask; wr_reg = 1'b1; end
        2'b01: begin result = reg_in |  bmask; wr_reg = 1'b1; end
        2'b10: skip = (reg_in & bmask) == '0;
        default: skip = (reg_in & bmask) != '0;
      endcase
    end else if (op[OPW-1 -: 3] == 3'b001 && op[3:0] != 4'h0) begin
      wr_acc = to_acc && op[3:0] != 4'h1;
      wr_reg = !(to_acc && op[3:0] != 4'h1);
      case (op[3:1])
        3'b000: z_we = 1'b1;
        3'b001: begin result = ~reg_in; z_we = 1'b1; end
        3'b010: begin result = inc_v; z_we = 1'b1; end
        3'b011: begin result = dec_v; skip = dec_v == '0; end
        3'b100: begin result = {c_in, reg_in[DW-1:1]}; c_out = reg_in[0]; c_we = 1'b1; end
        3'b101: begin result = {reg_in[DW-2:0], c_in}; c_out = reg_in[DW-1]; c_we = 1'b1; end
        3'b110: result = {reg_in[NIB-1:0], reg_in[DW-1:NIB]};
        default: begin result = inc_v; skip = inc_v == '0; end
      endcase
    end
  end
endmodule

module reg_op_unit_chk #(
  parameter int DW = 8,
  parameter int IW = 13,
  parameter int AW = 6
) (
  input logic [IW-1:0] instr,
  input logic [DW-1:0] reg_in,
  input logic          c_in,
  input logic [DW-1:0] result,
  input logic          wr_acc,
  input logic          wr_reg,
  input logic          z_we,
  input logic          z_out,
  input logic          c_we,
  input logic          c_out,
  input logic          skip
);
  always_comb begin
    if (!$isunknown({instr, reg_in, c_in})) begin
      assert_one_dest_R1: assert (!(wr_acc && wr_reg));
      assert_zero_flag_R13: assert (!z_we || (z_out == (result == '0)));
      assert_rot_c_only_R7: assert (!c_we || !z_we);
      assert_skip_noflag_R5: assert (!skip || (!z_we && !c_we));
      if (instr[IW-1] || instr[IW-1:AW] < 7'h11)
        assert_idle_R12: assert (!wr_acc && !wr_reg && !z_we && !c_we && !skip);
      if (instr[IW-1:IW-2] == 2'b01 && instr[IW-3:IW-4] == 2'b01)
        assert_bitset_R10: assert (result[instr[AW +: 3]] && (result | reg_in) == result
                                   && $countones(result ^ reg_in) <= 1);
      if (instr[IW-1:IW-2] == 2'b01 && instr[IW-3])
        assert_test_nowrite_R11: assert (!wr_acc && !wr_reg && !z_we && !c_we);
    end
  end
endmodule

bind reg_op_unit reg_op_unit_chk #(.DW(DW), .IW(IW), .AW(AW)) u_chk (
  .instr(instr), .reg_in(reg_in), .c_in(c_in), .result(result),
  .wr_acc(wr_acc), .wr_reg(wr_reg), .z_we(z_we), .z_out(z_out),
  .c_we(c_we), .c_out(c_out), .skip(skip)
);

// File: tb/reg_op_unit_bench.sv
module reg_op_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [12:0] instr = '0;
  logic [7:0]  reg_in = '0, acc_in = '0;
  logic        c_in = 1'b0;
  logic [7:0]  result;
  logic        wr_acc, wr_reg, z_we, z_out, c_we, c_out, skip;
  int          errors = 0, checks = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  reg_op_unit u_reg_op_unit (
    .instr(instr), .reg_in(reg_in), .acc_in(acc_in), .c_in(c_in),
    .result(result), .wr_acc(wr_acc), .wr_reg(wr_reg), .z_we(z_we),
    .z_out(z_out), .c_we(c_we), .c_out(c_out), .skip(skip)
  );

  // expected: {result, wr_acc, wr_reg, z_we, z_out, c_we, c_out, skip}
  task automatic expect_for(input logic [6:0] op, input logic [7:0] r, input logic c,
                            output logic [14:0] e, output string tag);
    logic [7:0] v;
    logic wa, wrg, zw, cw, co, sk;
    int b;
    v = r; wa = 0; wrg = 0; zw = 0; cw = 0; co = c; sk = 0; tag = "R12";
    b = op[2:0];
    if (op[6:5] == 2'b01) begin
      case (op[4:3])
        2'b00: begin v = r & ~(8'd1 << b); wrg = 1; tag = "R10"; end
        2'b01: begin v = r | (8'd1 << b); wrg = 1; tag = "R10"; end
        2'b10: begin sk = (r[b] == 1'b0); tag = "R11"; end
        default: begin sk = (r[b] == 1'b1); tag = "R11"; end
      endcase
    end else if (op >= 7'h11 && op <= 7'h1F) begin
      if (op == 7'h11) wrg = 1; else if (op % 2 == 0) wa = 1; else wrg = 1;
      if (op == 7'h11) begin v = r; zw = 1; tag = "R2"; end
      else if (op <= 7'h13) begin v = 8'(255 - r); zw = 1; tag = "R3"; end
      else if (op <= 7'h15) begin v = 8'((r + 1) % 256); zw = 1; tag = "R4"; end
      else if (op <= 7'h17) begin v = 8'((r + 255) % 256); sk = (v == 0); tag = "R5"; end
      else if (op <= 7'h19) begin v = 8'(r / 2 + 128 * c); co = r[0]; cw = 1; tag = "R7"; end
      else if (op <= 7'h1B) begin v = 8'((r * 2) % 256 + c); co = r[7]; cw = 1; tag = "R8"; end
      else if (op <= 7'h1D) begin v = 8'((r % 16) * 16 + r / 16); tag = "R9"; end
      else begin v = 8'((r + 1) % 256); sk = (v == 0); tag = "R6"; end
    end
    e = {v, wa, wrg, zw, zw && (v == 0), cw, co, sk};
  endtask

  task automatic check(input string tag, input logic [14:0] got, input logic [14:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s instr=%h reg=%h c=%b got=%h expected=%h", tag, instr, reg_in, c_in, got, exp);
    end
  endtask

  function automatic logic [14:0] masked(input logic [14:0] v, input logic [14:0] ref_v);
    logic [14:0] m;
    m = v;
    if (!ref_v[6] && !ref_v[5]) m[14:7] = '0;
    if (!ref_v[4]) m[3] = 1'b0;
    if (!ref_v[2]) m[1] = 1'b0;
    return m;
  endfunction

  initial begin
    logic [14:0] e;
    string tag;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset/idle state: all-zero word writes nothing (R12)
    check("R12", {wr_acc, wr_reg, z_we, c_we, skip}, 15'(0));
    // R1: a few explicit destination cases
    instr = {7'h14, 6'h05}; reg_in = 8'hFF; #2;
    check("R1", {wr_acc, wr_reg}, 15'(2'b10));
    check("R13", {z_we, z_out, result}, {5'b0, 1'b1, 1'b1, 8'h00});
    instr = {7'h11, 6'h05}; #2;
    check("R1", {wr_acc, wr_reg}, 15'(2'b01));
    instr = {7'h1F, 6'h05}; #2;
    check("R6", {skip, result}, 15'({1'b1, 8'h00}));
    for (int op = 0; op < 128; op++) begin
      for (int r = 0; r < 256; r++) begin
        for (int c = 0; c < 2; c++) begin
          instr = {7'(op), 6'(r ^ op)};
          reg_in = 8'(r);
          acc_in = 8'(~r);
          c_in = 1'(c);
          #1;
          expect_for(7'(op), 8'(r), 1'(c), e, tag);
          check(tag, masked({result, wr_acc, wr_reg, z_we, z_out, c_we, c_out, skip}, e), masked(e, e));
        end
      end
    end
    // R12: upper half of the instruction space is inert
    for (int k = 0; k < 64; k++) begin
      instr = 13'h1000 | 13'(k * 61);
      reg_in = 8'(k * 7); #1;
      check("R12", {wr_acc, wr_reg, z_we, c_we, skip}, 15'(0));
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired got=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule